// File: doc/BRIEF.md
# Pulse-Width Audio Output with Packed Sample Feed

This block turns unsigned 16-bit audio samples into a one-bit pulse-width output that an external low-pass filter smooths back into an analog waveform. An upstream producer hands over four samples at once, packed into a 64-bit word and qualified by a single-cycle write strobe. The block keeps one packed word in play and can hold the next one waiting. It releases one sample per audio sample period, starting with the lowest half-word.

A single system clock drives everything. A clock-enable divider produces the carrier step at the carrier rate. A five-bit carrier count steps through 25 positions, so one full carrier sweep lasts exactly one audio sample period. At every sweep boundary the next sample is rescaled to a duty level between 0 and 24 with a constant multiply and shift, and that level is applied for the whole sweep. If the producer falls behind, the last level keeps playing and a starvation flag is raised until fresh data is consumed.

Top module: `pwm_audio_dac`

## Requirements
- R1: A sample s maps to the duty level (s × 25) >> 16, so 0x0A3D gives 0, 0x0A3E gives 1, 0x51EB gives 7, 0x51EC gives 8, 0x8000 gives 12, 0xF5C2 gives 23, and both 0xF5C3 and 0xFFFF give 24.
- R2: In each sweep the output is high for exactly level × CARRIER_DIV system clocks, where CARRIER_DIV = CLK_HZ / CARRIER_HZ. Level 0 keeps the output low for the whole sweep, and level 24 keeps it high for 24 of the 25 carrier steps.
- R3: The four samples of a packed word play in consecutive sweeps in the order bits [15:0], [31:16], [47:32], [63:48].
- R4: The duty level changes only at the boundary between two sweeps. A write that lands in the middle of a sweep does not alter the output of that sweep.
- R5: When a sweep boundary arrives with no unplayed sample and no waiting word, the previous level is repeated and `starved_o` goes high. The flag drops at the next boundary where a sample is taken.
- R6: While a waiting word has not yet been started, a second write replaces it. Only the last word written is played.
- R7: While `rst_n` is low at a clock edge, the output goes low, the carrier count and the level go to zero, any held or waiting data is dropped, and `starved_o` is cleared. The first sweep after reset is fully low.
- R8: The carrier count advances by one every CARRIER_DIV clocks and wraps from 24 to 0. A sweep therefore lasts 25 × CARRIER_DIV clocks, which equals CLK_HZ / SAMPLE_HZ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_i | input | 64 | Four packed samples, lowest half-word played first |
| word_we_i | input | 1 | One-cycle strobe that captures `word_i` |
| pwm_o | output | 1 | Pulse-width output to the reconstruction filter |
| starved_o | output | 1 | High while a level is repeated because no data was available |

## Verification
The samples fed in sit on both sides of the rescaler's rounding steps: 0x0A3D and 0x0A3E, 0x51EB and 0x51EC, 0xF5C2 and 0xF5C3, together with 0x0000, 0x8000 and 0xFFFF. A missing or shifted multiply therefore moves at least one measured high-time by a whole carrier step. The words are not symmetric, so a reversed or stuck slot order would play the wrong level in some sweep. Words are written in the middle of sweeps, both while a word is still playing and while the block is starved, which separates mid-sweep reloading from loading at the boundary. A double write tells last-write-wins apart from first-write-wins, and the run-out case shows that the last level is held rather than dropped to zero. A reset in the middle of a run, with no data written afterwards, checks that the restart is clean.

// File: rtl/pwm_dac_pkg.sv
// Shared types for the pulse-width audio output.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_dac_pkg;

    // Source of the sample taken at a sweep boundary.
    typedef enum logic [1:0] {
        SRC_ACTIVE  = 2'd0,  // next slot of the word in play
        SRC_PENDING = 2'd1,  // first slot of the waiting word
        SRC_NONE    = 2'd2   // nothing available, repeat last level
    } feed_src_e;

endpackage

// File: rtl/pdac_tick_div.sv
// Clock-enable divider: raises step_o for one clock in every DIV clocks.
// Assumes: DIV >= 2; no clock is generated, only an enable.
module pdac_tick_div #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == CW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign step_o = (div_q == CW'(DIV - 1));
endmodule

// File: rtl/pdac_feeder.sv
// Sample feeder: captures packed words, hands out one slot per sweep
// (lowest half-word first) and rescales it to a duty level.
// Assumes: take_i pulses once per sweep; a write replaces a waiting word.
module pdac_feeder
    import pwm_dac_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOTS    = 4,
    parameter int LEVELS   = 25,
    parameter int CW       = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SAMPLE_W*SLOTS-1:0] word_i,
    input  logic                      we_i,
    input  logic                      take_i,
    output logic [CW-1:0]             lvl_o,
    output logic                      starved_o
);
    localparam int WORD_W = SAMPLE_W * SLOTS;
    localparam int PTRW   = $clog2(SLOTS + 1);
    localparam int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int PW     = SAMPLE_W + $clog2(LEVELS) + 1;

    logic [WORD_W-1:0]   act_q, pend_q;
    logic                pend_vld_q;
    logic [PTRW-1:0]     ptr_q;          // == SLOTS means word used up
    logic [CW-1:0]       lvl_q;
    logic                starved_q;
    logic [SAMPLE_W-1:0] slot_w [SLOTS];
    logic [SAMPLE_W-1:0] smp;
    logic [PW-1:0]       prod;
    feed_src_e           src;

    // Split the active word into its slots.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_w[g] = act_q[g*SAMPLE_W +: SAMPLE_W];
    end

    // Pick the source of the next sample.
    always_comb begin
        if (ptr_q != PTRW'(SLOTS)) begin
            src = SRC_ACTIVE;
            smp = slot_w[ptr_q[IW-1:0]];
        end else if (pend_vld_q) begin
            src = SRC_PENDING;
            smp = pend_q[SAMPLE_W-1:0];
        end else begin
            src = SRC_NONE;
            smp = '0;
        end
    end

    // Rescale to 0..LEVELS-1 with a constant multiply and shift.
    assign prod = PW'(smp) * PW'(LEVELS);

    // Waiting-word register; the last write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (we_i) begin
            pend_q     <= word_i;
            pend_vld_q <= 1'b1;
        end else if (take_i && src == SRC_PENDING) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Active word, slot pointer, level and starvation flag at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            ptr_q     <= PTRW'(SLOTS);
            lvl_q     <= '0;
            starved_q <= 1'b0;
        end else if (take_i) begin
            unique case (src)
                SRC_ACTIVE: begin
                    ptr_q     <= ptr_q + 1'b1;
                    lvl_q     <= prod[SAMPLE_W +: CW];
                    starved_q <= 1'b0;
                end
                SRC_PENDING: begin
                    act_q     <= pend_q;
                    ptr_q     <= PTRW'(1);
                    lvl_q     <= prod[SAMPLE_W +: CW];
                    starved_q <= 1'b0;
                end
                default: starved_q <= 1'b1;
            endcase
        end
    end

    assign lvl_o     = lvl_q;
    assign starved_o = starved_q;
endmodule

// File: rtl/pdac_carrier.sv
// Carrier counter and comparator: counts 0..LEVELS-1 on each step and
// drives the output high while the count is below the level.
// Assumes: lvl_i only changes on the clock after wrap_o.
module pdac_carrier #(
    parameter int LEVELS = 25,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] lvl_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          pwm_o
);
    logic [CW-1:0] cnt_q;
    logic          pwm_q;

    assign wrap_o = step_i && (cnt_q == CW'(LEVELS - 1));

    // Carrier position, advanced by the step enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap_o)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Registered compare so the output pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_q <= 1'b0;
        else
            pwm_q <= (cnt_q < lvl_i);
    end

    assign cnt_o = cnt_q;
    assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_audio_dac.sv
// Top: pulse-width audio output fed with four packed samples per word.
// Assumes: CLK_HZ divisible by CARRIER_HZ, CARRIER_HZ by SAMPLE_HZ.
module pwm_audio_dac #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int CARRIER_HZ = 200_000,
    parameter int SAMPLE_HZ  = 8_000,
    parameter int SAMPLE_W   = 16,
    parameter int SLOTS      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SAMPLE_W*SLOTS-1:0] word_i,
    input  logic                      word_we_i,
    output logic                      pwm_o,
    output logic                      starved_o
);
    localparam int DIV    = CLK_HZ / CARRIER_HZ;
    localparam int LEVELS = CARRIER_HZ / SAMPLE_HZ;
    localparam int CW     = $clog2(LEVELS);

    logic          step;
    logic          wrap;
    logic [CW-1:0] car_cnt;
    logic [CW-1:0] cur_lvl;

    pdac_tick_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .step_o(step)
    );

    pdac_feeder #(
        .SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS), .LEVELS(LEVELS), .CW(CW)
    ) u_feed (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .we_i(word_we_i),
        .take_i(wrap), .lvl_o(cur_lvl), .starved_o(starved_o)
    );

    pdac_carrier #(.LEVELS(LEVELS), .CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .step_i(step), .lvl_i(cur_lvl),
        .cnt_o(car_cnt), .wrap_o(wrap), .pwm_o(pwm_o)
    );
endmodule

// File: rtl/pdac_checker.sv
// Checker for pwm_audio_dac, attached by bind below.
// Assumes: synchronous active-low reset driven low from time zero.
module pdac_checker #(
    parameter int LEVELS = 25,
    parameter int CW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwm_o,
    input logic          starved_o,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] lvl,
    input logic          step,
    input logic          wrap
);
    // R7
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && lvl == '0 && !pwm_o && !starved_o));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(lvl));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LEVELS));

    // R1
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl < CW'(LEVELS));

    // R2
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl == '0 |=> !pwm_o);

    // R5
    starve_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(starved_o) |-> $past(wrap));
endmodule

bind pwm_audio_dac pdac_checker #(.LEVELS(LEVELS), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .starved_o(starved_o),
    .cnt(car_cnt), .lvl(cur_lvl), .step(step), .wrap(wrap)
);

// File: tb/pwm_audio_dac_tb_top.sv
// Bench for pwm_audio_dac: a vector table of sweeps, then reset cases.
module pwm_audio_dac_tb_top;
    localparam int CLK_HZ = 2_000_000;           // scaled so sweeps are short
    localparam int DIV    = CLK_HZ / 200_000;    // 10 clocks per step
    localparam int SWEEP  = 25 * DIV;            // clocks per sweep
    localparam int NV     = 22;

    typedef struct packed {
        logic        wr1;
        logic [63:0] w1;
        logic        wr2;
        logic [63:0] w2;
        logic [4:0]  lvl;
        logic        st;
    } vec_t;

    // Per sweep: writes made during it, level and flag expected in it.
    localparam vec_t TBL [NV] = '{
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd0,  1'b0},                     // W0 slot0
        '{1'b1, 64'hF5C2_F5C3_51EC_51EB, 1'b0, 64'h0, 5'd1,  1'b0},   // W0 slot1
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd12, 1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd24, 1'b0},
        '{1'b1, 64'hC000_0A3D_4000_0001, 1'b0, 64'h0, 5'd7, 1'b0},    // W1 slot0
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd8,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd24, 1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd23, 1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd0,  1'b0},                     // W2 slot0
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd6,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd0,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd18, 1'b0},
        '{1'b1, 64'h0000_FFFF_0A3D_8000, 1'b0, 64'h0, 5'd18, 1'b1},   // starved
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd12, 1'b0},                     // W3 slot0
        '{1'b1, 64'h0000_0000_0000_FFFF, 1'b1, 64'h1111_2222_3333_4000, 5'd0, 1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd24, 1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd0,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd6,  1'b0},                     // second write won
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd4,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd3,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd1,  1'b0},
        '{1'b0, 64'h0, 1'b0, 64'h0, 5'd1,  1'b1}                      // starved again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] word_i = '0;
    logic        word_we_i = 1'b0;
    logic        pwm_o, starved_o;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_audio_dac #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_we_i(word_we_i),
        .pwm_o(pwm_o), .starved_o(starved_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sweep: optional mid-sweep writes, count high clocks, read flag.
    task automatic run_sweep(input logic wr1, input logic [63:0] w1,
                             input logic wr2, input logic [63:0] w2,
                             output int highs, output logic st);
        highs = 0;
        st = 1'b0;
        for (int i = 0; i < SWEEP; i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
            if (i == SWEEP - 2) st = starved_o;
            word_we_i = 1'b0;
            if (i == 3 && wr1) begin word_i = w1; word_we_i = 1'b1; end
            if (i == 6 && wr2) begin word_i = w2; word_we_i = 1'b1; end
        end
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int   h;
        logic s;
        repeat (3) @(negedge clk);
        check("R7 pwm in reset", int'(pwm_o), 0);
        check("R7 starved in reset", int'(starved_o), 0);
        rst_n = 1'b1;

        // Sweep 0: first word written, output must stay low.
        run_sweep(1'b1, 64'hFFFF_8000_0A3E_0000, 1'b0, 64'h0, h, s);
        check("R7 first sweep highs", h, 0);

        // Vector walk: R1/R2/R3/R4/R5/R6/R8.
        for (int v = 0; v < NV; v++) begin
            run_sweep(TBL[v].wr1, TBL[v].w1, TBL[v].wr2, TBL[v].w2, h, s);
            check($sformatf("R1/R2/R3/R8 sweep %0d highs", v + 1), h,
                  int'(TBL[v].lvl) * DIV);
            check($sformatf("R5 sweep %0d starved", v + 1), int'(s),
                  int'(TBL[v].st));
        end

        // R6: a word left waiting, then reset mid-sweep drops it.
        @(negedge clk);
        word_i = 64'hFFFF_FFFF_FFFF_FFFF;
        word_we_i = 1'b1;
        repeat (40) @(negedge clk);
        word_we_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 pwm after mid-run reset", int'(pwm_o), 0);
        check("R7 starved after mid-run reset", int'(starved_o), 0);
        rst_n = 1'b1;
        run_sweep(1'b0, 64'h0, 1'b0, 64'h0, h, s);
        check("R7 sweep 0 after reset highs", h, 0);
        check("R7 sweep 0 after reset starved", int'(s), 0);
        run_sweep(1'b0, 64'h0, 1'b0, 64'h0, h, s);
        check("R5/R7 no data after reset highs", h, 0);
        check("R5 no data after reset starved", int'(s), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule